// File: doc/BRIEF.md
# SCSI Bus Status Register

This block presents one read-only status byte for a SCSI protocol controller. It brings the raw active-low bus control lines through a two-flop synchronizer. It reports ACK and ATN directly. It keeps three sticky latches: a busy-loss error, a parity error and an interrupt-active flag. It also keeps a live phase-match flag, which compares the bus phase lines (MSG, C/D, I/O) with the phase the controller expects.

A CPU reads the byte by strobing `cpu_rd` with `cpu_addr` set to the status address. A strobe at the clear address wipes the parity and interrupt latches. If the bus drops BSY while busy monitoring is enabled, the block raises `out_disable` so that the rest of the controller takes its bus drivers off. It also sends a one-cycle `dma_mode_clr` pulse so that the mode logic drops DMA mode. The DMA request and end-of-DMA bits come in from the DMA engine and are only reported here.

Top module: `bus_status_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rd_data`, `irq`, `out_disable` and `dma_mode_clr` are 0. With the bus idle (all `_n` lines high), `tcmd_phase` = 0 and `mode_reg` = 0, a status read returns 0x08.
- R2: The status byte carries, from bit 0 upward: ACK, ATN, busy error, phase match, interrupt active, parity error, DMA request, end of DMA. An active-low bus line shows as 1 when it is driven low. `dma_req` and `dma_end` are reported as they are, without synchronization.
- R3: Status bit 3 is 1 exactly when the asserted states of {MSG, C/D, I/O} equal `tcmd_phase`. MSG compares against bit 2 and I/O against bit 0. The flag follows the bus continuously.
- R4: The busy error sets when `mode_reg` bit 2 is 1 and BSY is deasserted (synchronized `bus_bsy_n` high). It stays set until `rst` or until `mode_reg` bit 2 is 0. `out_disable` is high whenever the busy error is set.
- R5: `dma_mode_clr` pulses high for exactly one cycle each time the busy error goes from clear to set.
- R6: A `par_fail` strobe sets the sticky parity error (status bit 5) only while `mode_reg` bit 5 is 1. With bit 5 at 0 the strobe has no effect.
- R7: Any bit of `irq_src` at 1 sets the interrupt latch in the next cycle. `irq` and status bit 4 report this same latch.
- R8: A read strobe at address CLR_ADDR (default 7) clears the parity error and interrupt latches. If a set condition is present in the same cycle, the set wins.
- R9: `rd_data` updates one cycle after a read strobe. A strobe at STAT_ADDR (default 5) returns the status byte, a strobe at any other address returns 0, and `rd_data` holds its value while `cpu_rd` is low.
- R10: Count rising edges from an ACK or ATN line change, with the first edge after the change as edge 1. A read strobe sampled at edge 3 still returns the old value. One sampled at edge 4 or later returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ack_n | input | 1 | Bus ACK line, active low, asynchronous |
| bus_atn_n | input | 1 | Bus ATN line, active low, asynchronous |
| bus_bsy_n | input | 1 | Bus BSY line, active low, asynchronous |
| bus_msg_n | input | 1 | Bus MSG phase line, active low |
| bus_cd_n | input | 1 | Bus C/D phase line, active low |
| bus_io_n | input | 1 | Bus I/O phase line, active low |
| mode_reg | input | 8 | Mode bits; bit 2 monitors busy, bit 5 enables parity check |
| tcmd_phase | input | 3 | Expected phase {MSG, C/D, I/O} |
| par_fail | input | 1 | One-cycle parity failure strobe |
| irq_src | input | IRQ_SRCS | Enabled interrupt conditions |
| dma_req | input | 1 | DMA request state to report |
| dma_end | input | 1 | End-of-DMA state to report |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | ADDR_W | CPU register address |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| out_disable | output | 1 | Forces bus outputs off after a busy loss |
| dma_mode_clr | output | 1 | One-cycle request to clear DMA mode |

## Verification
The phase comparison is swept over all 64 pairs of bus phase and expected phase, with the whole status byte compared each time. This separates a swapped line order or an inverted line from a correct compare. All four ACK/ATN combinations and the DMA bits are stepped through to pin down each bit position. One read at edge 3 and one at edge 4 after a change confirm the synchronizer depth. Each latch is driven with its enable both off and on, and with set and clear in the same cycle. Each interrupt source is raised alone. The busy loss is also started with BSY still asserted, which separates the set condition from the busy-monitor bit alone.

// File: rtl/bstat_pkg.sv
package bstat_pkg;

  localparam int STAT_W = 8;
  localparam int PH_W   = 3;

  // status byte bit positions (decoded by software)
  localparam int SB_ACK  = 0;
  localparam int SB_ATN  = 1;
  localparam int SB_BUSY = 2;
  localparam int SB_PHM  = 3;
  localparam int SB_IRQ  = 4;
  localparam int SB_PAR  = 5;
  localparam int SB_DRQ  = 6;
  localparam int SB_DEND = 7;

  // mode register bit positions
  localparam int MD_MONBSY = 2;
  localparam int MD_PAREN  = 5;

  // bus control lines, 1 = asserted
  typedef struct packed {
    logic ack;
    logic atn;
    logic bsy;
    logic msg;
    logic cd;
    logic io;
  } bus_lines_t;

  localparam int BUS_W = $bits(bus_lines_t);

endpackage

// File: rtl/bstat_sync.sv
module bstat_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];

endmodule

// File: rtl/bstat_phase.sv
module bstat_phase #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] bus_phase,
  input  logic [PW-1:0] exp_phase,
  output logic          match_q
);

  logic [PW-1:0] diff;

  always_comb diff = bus_phase ^ exp_phase;

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= (diff == '0);
  end

endmodule

// File: rtl/bstat_sticky.sv
module bstat_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_en,
  input  logic set_req,
  input  logic clr_req,
  output logic q
);

  logic do_set;

  always_comb do_set = set_en & set_req;

  always_ff @(posedge clk) begin
    if (rst)          q <= 1'b0;
    else if (do_set)  q <= 1'b1;
    else if (clr_req) q <= 1'b0;
  end

  // R6/R8: a latch only rises through a gated set request
  a_r6_gated_set: assert property (@(posedge clk) disable iff (rst)
    !q |=> (!q || $past(set_en && set_req)));

  // R8: clear without a set empties the latch
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !(set_en && set_req)) |=> !q);

endmodule

// File: rtl/bstat_busy.sv
module bstat_busy (
  input  logic clk,
  input  logic rst,
  input  logic mon_busy,
  input  logic bsy_on,
  output logic busy_err,
  output logic dma_clr
);

  logic loss;

  always_comb loss = mon_busy & ~bsy_on;

  always_ff @(posedge clk) begin
    if (rst || !mon_busy) busy_err <= 1'b0;
    else if (loss)        busy_err <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) dma_clr <= 1'b0;
    else     dma_clr <= loss & ~busy_err;
  end

  // R4: sticky while monitoring stays on
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    (busy_err && mon_busy) |=> busy_err);

  // R5: the clear request is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    dma_clr |=> !dma_clr);

  // R5: the pulse comes only with a freshly set error
  a_r5_with_error: assert property (@(posedge clk) disable iff (rst)
    dma_clr |-> (busy_err && !$past(busy_err)));

endmodule

// File: rtl/bus_status_unit.sv
module bus_status_unit
  import bstat_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int STAT_ADDR   = 5,
  parameter int CLR_ADDR    = 7,
  parameter int IRQ_SRCS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_ack_n,
  input  logic                bus_atn_n,
  input  logic                bus_bsy_n,
  input  logic                bus_msg_n,
  input  logic                bus_cd_n,
  input  logic                bus_io_n,
  input  logic [STAT_W-1:0]   mode_reg,
  input  logic [PH_W-1:0]     tcmd_phase,
  input  logic                par_fail,
  input  logic [IRQ_SRCS-1:0] irq_src,
  input  logic                dma_req,
  input  logic                dma_end,
  input  logic                cpu_rd,
  input  logic [ADDR_W-1:0]   cpu_addr,
  output logic [STAT_W-1:0]   rd_data,
  output logic                irq,
  output logic                out_disable,
  output logic                dma_mode_clr
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_ADDR);

  logic [BUS_W-1:0] raw_n, sync_n;
  bus_lines_t       lines;
  logic             phase_match, busy_err, par_err, irq_q, clr_rd;
  logic [STAT_W-1:0] stat_d, stat_q;

  assign raw_n = {bus_ack_n, bus_atn_n, bus_bsy_n, bus_msg_n, bus_cd_n, bus_io_n};

  bstat_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst(rst), .d_in(raw_n), .d_out(sync_n)
  );

  always_comb lines = bus_lines_t'(~sync_n);

  bstat_phase #(.PW(PH_W)) u_phase (
    .clk(clk), .rst(rst),
    .bus_phase({lines.msg, lines.cd, lines.io}),
    .exp_phase(tcmd_phase),
    .match_q(phase_match)
  );

  bstat_busy u_busy (
    .clk(clk), .rst(rst),
    .mon_busy(mode_reg[MD_MONBSY]),
    .bsy_on(lines.bsy),
    .busy_err(busy_err),
    .dma_clr(dma_mode_clr)
  );

  always_comb clr_rd = cpu_rd && (cpu_addr == A_CLR);

  bstat_sticky u_par (
    .clk(clk), .rst(rst),
    .set_en(mode_reg[MD_PAREN]), .set_req(par_fail),
    .clr_req(clr_rd), .q(par_err)
  );

  bstat_sticky u_irq (
    .clk(clk), .rst(rst),
    .set_en(1'b1), .set_req(|irq_src),
    .clr_req(clr_rd), .q(irq_q)
  );

  assign irq         = irq_q;
  assign out_disable = busy_err;

  always_comb begin
    stat_d          = '0;
    stat_d[SB_ACK]  = lines.ack;
    stat_d[SB_ATN]  = lines.atn;
    stat_d[SB_BUSY] = busy_err;
    stat_d[SB_PHM]  = phase_match;
    stat_d[SB_IRQ]  = irq_q;
    stat_d[SB_PAR]  = par_err;
    stat_d[SB_DRQ]  = dma_req;
    stat_d[SB_DEND] = dma_end;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (cpu_rd) rd_data <= (cpu_addr == A_STAT) ? stat_q : '0;
  end

  // R7: the status image of the interrupt bit trails the pin by one register
  a_r7_irq_mirror: assert property (@(posedge clk) disable iff (rst)
    stat_q[SB_IRQ] == $past(irq));

  // R9: read data only moves on a strobe
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> $stable(rd_data));

  // R4: outputs stay off whenever the busy latch is reported set
  a_r4_disable: assert property (@(posedge clk) disable iff (rst)
    stat_q[SB_BUSY] |-> ($past(out_disable)));

endmodule

// File: tb/bus_status_unit_test.sv
module bus_status_unit_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic ack_n, atn_n, bsy_n, msg_n, cd_n, io_n;
  logic [7:0] mode;
  logic [2:0] tph;
  logic par_fail, dreq, dend, cpu_rd;
  logic [3:0] isrc;
  logic [2:0] addr;
  logic [7:0] rd_data;
  logic irq, out_dis, dclr;

  int checks = 0;
  int errors = 0;
  int pulses = 0;

  bus_status_unit uut (
    .clk(clk), .rst(rst),
    .bus_ack_n(ack_n), .bus_atn_n(atn_n), .bus_bsy_n(bsy_n),
    .bus_msg_n(msg_n), .bus_cd_n(cd_n), .bus_io_n(io_n),
    .mode_reg(mode), .tcmd_phase(tph), .par_fail(par_fail),
    .irq_src(isrc), .dma_req(dreq), .dma_end(dend),
    .cpu_rd(cpu_rd), .cpu_addr(addr),
    .rd_data(rd_data), .irq(irq), .out_disable(out_dis), .dma_mode_clr(dclr)
  );

  always @(negedge clk) if (!rst && dclr) pulses++;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cpu_rd = 1'b1; addr = a;
    @(negedge clk); cpu_rd = 1'b0; d = rd_data;
  endtask

  function automatic logic [7:0] stat(input logic ack, atn, busy, phm, iq, par, drq, de);
    return {de, drq, par, iq, phm, busy, atn, ack};
  endfunction

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] d, hold;
    rst = 1'b1; {ack_n, atn_n, bsy_n, msg_n, cd_n, io_n} = '1;
    mode = '0; tph = '0; par_fail = 0; dreq = 0; dend = 0;
    cpu_rd = 0; addr = '0; isrc = '0;
    edges(3);
    @(negedge clk);
    chk("R1 outputs in reset", {rd_data[3:0], irq, out_dis, dclr, 1'b0}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs after reset", {rd_data[3:0], irq, out_dis, dclr, 1'b0}, 8'h00);
    edges(4);
    rd(3'd5, d); chk("R1 idle status", d, 8'h08);

    // R2: ACK/ATN and DMA bits, all combinations
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      ack_n = ~v[0]; atn_n = ~v[1]; dreq = v[2]; dend = v[3];
      edges(4); rd(3'd5, d);
      chk("R2 bit layout", d, stat(v[0], v[1], 0, 1, 0, 0, v[2], v[3]));
    end
    @(negedge clk); ack_n = 1; atn_n = 1; dreq = 0; dend = 0;

    // R3: all 64 bus phase / expected phase pairs
    for (int p = 0; p < 8; p++) begin
      for (int e = 0; e < 8; e++) begin
        @(negedge clk);
        msg_n = ~p[2]; cd_n = ~p[1]; io_n = ~p[0]; tph = 3'(e);
        edges(4); rd(3'd5, d);
        chk("R3 phase match", d, stat(0, 0, 0, (p == e), 0, 0, 0, 0));
      end
    end
    @(negedge clk); {msg_n, cd_n, io_n} = '1; tph = '0;

    // R10: synchronizer latency on ACK
    edges(5);
    @(negedge clk); ack_n = 0;
    edges(2); rd(3'd5, d); chk("R10 edge 3 still old", d, 8'h08);
    @(negedge clk); ack_n = 1;
    edges(4);
    @(negedge clk); ack_n = 0;
    edges(3); rd(3'd5, d); chk("R10 edge 4 new", d, 8'h09);
    @(negedge clk); ack_n = 1; edges(4);

    // R9: other addresses read 0, data holds without strobe
    for (int a = 0; a < 8; a++) begin
      if (a != 5) begin
        rd(3'(a), d); chk("R9 other address", d, 8'h00);
      end
    end
    rd(3'd5, d);
    hold = rd_data;
    edges(6); @(negedge clk);
    chk("R9 hold", rd_data, hold);

    // R7: each interrupt source alone; R8 clear
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); isrc = 4'(1 << s);
      @(negedge clk); isrc = '0;
      chk("R7 irq pin", {7'd0, irq}, 8'h01);
      edges(2); rd(3'd5, d);
      chk("R7 status irq", d, stat(0, 0, 0, 1, 1, 0, 0, 0));
      rd(3'd7, d);
      chk("R8 irq cleared", {7'd0, irq}, 8'h00);
    end
    // R8: set wins over clear
    @(negedge clk); isrc = 4'b0100;
    rd(3'd7, d);
    chk("R8 set wins", {7'd0, irq}, 8'h01);
    @(negedge clk); isrc = '0;
    rd(3'd7, d);
    chk("R8 cleared after", {7'd0, irq}, 8'h00);

    // R6: parity gate
    @(negedge clk); par_fail = 1;
    @(negedge clk); par_fail = 0;
    edges(2); rd(3'd5, d);
    chk("R6 disabled parity ignored", d, 8'h08);
    @(negedge clk); mode[5] = 1; par_fail = 1;
    @(negedge clk); par_fail = 0;
    edges(4); rd(3'd5, d);
    chk("R6 parity set", d, stat(0, 0, 0, 1, 0, 1, 0, 0));
    edges(4); rd(3'd5, d);
    chk("R6 parity sticky", d, stat(0, 0, 0, 1, 0, 1, 0, 0));
    rd(3'd7, d); edges(2); rd(3'd5, d);
    chk("R8 parity cleared", d, 8'h08);
    @(negedge clk); mode[5] = 0;

    // R4: BSY asserted with monitor on -> no error
    @(negedge clk); bsy_n = 0; edges(4);
    @(negedge clk); mode[2] = 1;
    edges(4); @(negedge clk);
    chk("R4 no error while BSY held", {7'd0, out_dis}, 8'h00);
    chk("R5 no pulse yet", 8'(pulses), 8'd0);
    // BSY lost
    @(negedge clk); bsy_n = 1;
    edges(4); @(negedge clk);
    chk("R4 disable on loss", {7'd0, out_dis}, 8'h01);
    rd(3'd5, d); chk("R4 status busy", d, stat(0, 0, 1, 1, 0, 0, 0, 0));
    @(negedge clk); bsy_n = 0;
    edges(5); @(negedge clk);
    chk("R4 sticky after BSY returns", {7'd0, out_dis}, 8'h01);
    chk("R5 one pulse", 8'(pulses), 8'd1);
    @(negedge clk); mode[2] = 0;
    @(negedge clk);
    chk("R4 cleared by mode bit", {7'd0, out_dis}, 8'h00);
    // second loss, then reset clears it
    @(negedge clk); bsy_n = 1; mode[2] = 1;
    edges(4); @(negedge clk);
    chk("R5 second pulse", 8'(pulses), 8'd2);
    rst = 1; @(negedge clk); rst = 0; mode[2] = 0;
    chk("R4 cleared by reset", {7'd0, out_dis}, 8'h00);

    finish_run();
  end

endmodule